// File: doc/BRIEF.md
# Read-to-Acquire Hardware Lock Engine

This block is a memory-mapped lock peripheral for a shared-bus multiprocessor. A processor takes the lock with one ordinary load from the lock word. If the lock is free, that load returns zero and, as a side effect of the same access, the engine marks the lock as held. A processor that reads a non-zero value has been refused and polls again. A plain store to the lock word, whatever the data, gives the lock back. The processor needs no atomic swap, no exclusive monitor and no locked bus cycle, so every CPU family on the bus uses the same acquire and release sequence.

A four-state machine drives the lock word. From idle, a winning read moves it to a sampling state. A commit state then writes the held code into the lock register, and a hold state waits for the release store before returning to idle. Every state other than idle reads back as held. A second read in the cycle right after a winning read is therefore already refused, even though the held code has not yet been committed.

The slave port completes each access in one cycle. It has a select, a read strobe, a write strobe, a byte address and 32-bit data. Read data are valid combinationally in the cycle of the read strobe. The engine decodes a 128 KiB window starting at 0xB0000.

Top module: `sem_engine`

## Requirements
- R1: After reset the lock is free: the first read of the lock word returns 0x0000_0000.
- R2: The lock word occupies byte addresses 0xB0000 to 0xB0003; address bits [1:0] are not decoded. An access counts only while the select is high.
- R3: A read of the lock word while the lock is free returns 0x0000_0000 and takes the lock.
- R4: The value returned by a read is the value before that read's side effect. Of two lock-word reads in consecutive cycles, at most one returns 0; the second returns the held code 0x0000_0001.
- R5: While the lock is held, every read of the lock word returns 0x0000_0001, however long the holder keeps it.
- R6: Any write to the lock word, whatever its data value, frees the lock; the next read returns 0.
- R7: A write to the lock word while the lock is free has no effect: the lock stays free and the next read acquires it.
- R8: A release write that arrives one, two or three or more cycles after the acquiring read (in the sampling, commit or hold state) frees the lock.
- R9: A cycle with both read and write strobes on the lock word is treated as a write. Its read data are 0x0000_0001, and the lock is free afterwards.
- R10: Other addresses inside the window (offsets 0x00004 to 0x1FFFF) read as 0, and writes to them do not release the lock.
- R11: Addresses outside the window, and accesses with the select low, read as 0 and neither take nor release the lock.
- R12: The read data are 0 in any cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Slave select; strobes are ignored while low |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 20 | Byte address |
| bus_wdata | input | 32 | Write data; any value releases the lock |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |

## Verification
Single acquire-and-release sequences are driven with the release store placed zero to three idle cycles after the winning read. This separates a release that lands in the sampling, commit or hold state. Back-to-back reads show whether the value returned is the one before or after the read's own side effect. Combined read-and-write cycles, release stores with several data patterns, and stores while the lock is free show that write priority and the data value do not matter. A sweep over the whole address window, the addresses just outside it and the deselected case, followed by a long pseudo-random mix of accesses checked against an arithmetic lock model, shows that only the lock word ever changes or reports the lock.

// File: rtl/sem_engine_pkg.sv
// Shared types for the read-to-acquire lock engine.
// Assumes: a single lock word per engine instance.
package sem_engine_pkg;

    // Lock state machine encoding: idle plus three working states.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,  // lock free, register holds zero
        ST_SAMPLE = 2'd1,  // a winning read was just seen
        ST_COMMIT = 2'd2,  // held code is being written into the register
        ST_HELD   = 2'd3   // waiting for the release write
    } sem_state_e;

endpackage

// File: rtl/sem_addr_dec.sv
// Address decoder for the lock engine window.
// What it does: flags whether the access falls inside the engine window and
// whether it targets the lock word (word granularity, low two bits ignored).
// Assumes: WIN_BASE + WIN_SPAN fits in ADDR_W+1 bits.
module sem_addr_dec #(
    parameter int unsigned          ADDR_W   = 20,
    parameter logic [ADDR_W-1:0]    WIN_BASE = 20'hB0000,
    parameter logic [ADDR_W-1:0]    WIN_SPAN = 20'h20000,
    parameter logic [ADDR_W-1:0]    LOCK_OFS = 20'h00000
) (
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output logic              lock_hit
);

    localparam logic [ADDR_W:0] LO_BOUND = {1'b0, WIN_BASE};
    localparam logic [ADDR_W:0] HI_BOUND = {1'b0, WIN_BASE} + {1'b0, WIN_SPAN};
    localparam logic [ADDR_W-1:0] LOCK_WORD = LOCK_OFS >> 2;

    logic [ADDR_W:0]   addr_wide;
    logic [ADDR_W-1:0] offset;

    // Window membership and lock-word match for the current access.
    always_comb begin
        addr_wide = {1'b0, addr};
        offset    = addr - WIN_BASE;
        in_win    = sel && (addr_wide >= LO_BOUND) && (addr_wide < HI_BOUND);
        lock_hit  = in_win && ((offset >> 2) == LOCK_WORD);
    end

endmodule

// File: rtl/sem_lock_fsm.sv
// Lock state machine.
// What it does: moves idle -> sample on a winning read, sample -> commit ->
// held, where the held code is written into the lock register; any release
// write returns to idle with the register cleared.
// Assumes: acq_rd is never high together with rel_wr (the top masks it).
module sem_lock_fsm
    import sem_engine_pkg::*;
#(
    parameter int unsigned        DATA_W    = 32,
    parameter logic [DATA_W-1:0]  HELD_CODE = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_rd,
    input  logic              rel_wr,
    output logic              busy,
    output logic [DATA_W-1:0] lock_q
);

    sem_state_e state, state_nxt;

    // Next-state selection; a release write always wins.
    always_comb begin
        state_nxt = state;
        if (rel_wr) begin
            state_nxt = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:   if (acq_rd) state_nxt = ST_SAMPLE;
                ST_SAMPLE: state_nxt = ST_COMMIT;
                ST_COMMIT: state_nxt = ST_HELD;
                ST_HELD:   state_nxt = ST_HELD;
                default:   state_nxt = ST_IDLE;
            endcase
        end
    end

    // State register and the lock register it controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            lock_q <= '0;
        end else begin
            state <= state_nxt;
            if (rel_wr) begin
                lock_q <= '0;
            end else if (state == ST_COMMIT) begin
                lock_q <= HELD_CODE;
            end
        end
    end

    // Any working state counts as held for readers.
    always_comb busy = (state != ST_IDLE);

    // R1: in idle the lock register is free
    assert_idle_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (lock_q == '0));

    // R3: a winning read leaves idle
    assert_acquire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && acq_rd && !rel_wr) |=> (state == ST_SAMPLE));

    // R5: sample -> commit -> held with the held code stored
    assert_sample_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAMPLE && !rel_wr) |=> (state == ST_COMMIT));
    assert_commit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT && !rel_wr) |=> (state == ST_HELD && lock_q == HELD_CODE));
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && !rel_wr) |=> (state == ST_HELD && $stable(lock_q)));

    // R6: a release write frees the lock from any state
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rel_wr |=> (state == ST_IDLE && lock_q == '0));

    // R11: without a winning read the engine stays idle
    assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !acq_rd) |=> (state == ST_IDLE));

endmodule

// File: rtl/sem_rd_mux.sv
// Read data selection.
// What it does: returns the pre-side-effect lock value for a lock-word read,
// the held code when the lock is busy or the read collides with a write, and
// zero otherwise.
// Assumes: lock_q is zero whenever busy is low.
module sem_rd_mux #(
    parameter int unsigned        DATA_W    = 32,
    parameter logic [DATA_W-1:0]  HELD_CODE = 32'h0000_0001
) (
    input  logic              lock_rd,
    input  logic              lock_wr,
    input  logic              busy,
    input  logic [DATA_W-1:0] lock_q,
    output logic [DATA_W-1:0] rdata
);

    // Pick the value seen by the current read.
    always_comb begin
        if (!lock_rd) begin
            rdata = '0;
        end else if (lock_wr || busy) begin
            rdata = HELD_CODE;
        end else begin
            rdata = lock_q;
        end
    end

endmodule

// File: rtl/sem_engine.sv
// Read-to-acquire lock engine, top level.
// What it does: a single-cycle slave exposing one lock word; a read of a free
// lock returns zero and takes it, any write to the lock word releases it.
// Assumes: one access per cycle; a cycle with both strobes is a write.
module sem_engine
    import sem_engine_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 20,
    parameter int unsigned        DATA_W    = 32,
    parameter logic [ADDR_W-1:0]  WIN_BASE  = 20'hB0000,
    parameter logic [ADDR_W-1:0]  WIN_SPAN  = 20'h20000,
    parameter logic [ADDR_W-1:0]  LOCK_OFS  = 20'h00000,
    parameter logic [DATA_W-1:0]  HELD_CODE = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    logic              in_win;
    logic              lock_hit;
    logic              lock_rd;
    logic              lock_wr;
    logic              acq_rd;
    logic              busy;
    logic [DATA_W-1:0] lock_q;

    sem_addr_dec #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_SPAN (WIN_SPAN),
        .LOCK_OFS (LOCK_OFS)
    ) u_dec (
        .sel      (bus_sel),
        .addr     (bus_addr),
        .in_win   (in_win),
        .lock_hit (lock_hit)
    );

    // Qualify strobes with the lock-word hit; writes take priority.
    always_comb begin
        lock_rd = lock_hit && bus_rd;
        lock_wr = lock_hit && bus_wr;
        acq_rd  = lock_rd && !lock_wr;
    end

    sem_lock_fsm #(
        .DATA_W    (DATA_W),
        .HELD_CODE (HELD_CODE)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .acq_rd (acq_rd),
        .rel_wr (lock_wr),
        .busy   (busy),
        .lock_q (lock_q)
    );

    sem_rd_mux #(
        .DATA_W    (DATA_W),
        .HELD_CODE (HELD_CODE)
    ) u_mux (
        .lock_rd (lock_rd),
        .lock_wr (lock_wr),
        .busy    (busy),
        .lock_q  (lock_q),
        .rdata   (bus_rdata)
    );

    // R4: two consecutive winning reads are impossible
    assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_rd && bus_rdata == '0) |=> !(acq_rd && bus_rdata == '0));

    // R6: a release store with any defined data leaves the lock free
    assert_release_any_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && !$isunknown(bus_wdata)) |=> (!busy && lock_q == '0));

    // R9: a colliding read and write never reports the lock as free
    assert_collide_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_rd && lock_wr) |-> (bus_rdata == HELD_CODE));

    // R10: non-lock addresses inside the window read as zero
    assert_window_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && !lock_hit) |-> (bus_rdata == '0));

    // R12: no read strobe, no read data
    assert_idle_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));

endmodule

// File: tb/sem_engine_test.sv
// Self-checking bench for sem_engine: directed sweeps plus a pseudo-random
// mix, all checked against an arithmetic lock model.
module sem_engine_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] HELD = 32'h0000_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit model_free = 1'b1;
    bit done = 1'b0;

    sem_engine uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit is_lock(input logic [19:0] a);
        return (a >= 20'hB0000) && (a <= 20'hB0003);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One bus cycle: drive at negedge, check combinational read data, update model.
    task automatic op(input bit s, input bit r, input bit w, input logic [19:0] a,
                      input logic [31:0] d, input string tag);
        logic [31:0] exp;
        bit hit;
        @(negedge clk);
        bus_sel = s; bus_rd = r; bus_wr = w; bus_addr = a; bus_wdata = d;
        #1;
        hit = s && is_lock(a);
        if (hit && r) exp = (w || !model_free) ? HELD : 32'h0;
        else          exp = 32'h0;
        check(tag, bus_rdata, exp);
        if (hit && w)                   model_free = 1'b1;
        else if (hit && r && model_free) model_free = 1'b0;
    endtask

    task automatic idle_cyc(input int n, input string tag);
        for (int i = 0; i < n; i++) op(1'b0, 1'b0, 1'b0, 20'h0, 32'h0, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R12 and R1: quiet bus reads zero, first lock read wins
        idle_cyc(1, "R12 quiet bus");
        op(1, 1, 0, 20'hB0000, 0, "R1 first read after reset");

        // R4: back-to-back reads, second refused
        op(1, 1, 0, 20'hB0000, 0, "R4 read right after winner");
        // R5: long hold
        for (int i = 0; i < 8; i++) op(1, 1, 0, 20'hB0000, 0, "R5 polling while held");
        idle_cyc(3, "R12 idle while held");
        op(1, 1, 0, 20'hB0000, 0, "R5 still held");
        op(1, 0, 1, 20'hB0000, 32'h1, "R6 release");
        op(1, 1, 0, 20'hB0000, 0, "R6 read after release");
        op(1, 0, 1, 20'hB0000, 32'h1, "R6 release");

        // R6: release data patterns
        foreach (lfsr[i]) begin end
        for (int k = 0; k < 4; k++) begin
            logic [31:0] pat;
            pat = (k == 0) ? 32'h0 : (k == 1) ? 32'hFFFF_FFFF : (k == 2) ? 32'hA5A5_5A5A : 32'h8000_0000;
            op(1, 1, 0, 20'hB0000, 0, "R3 acquire");
            idle_cyc(2, "R12 gap");
            op(1, 0, 1, 20'hB0000, pat, "R6 release data pattern");
            op(1, 1, 0, 20'hB0000, 0, "R6 free after pattern");
            op(1, 0, 1, 20'hB0000, 32'h1, "R6 release");
        end

        // R8: release 0..3 idle cycles after the winning read
        for (int dly = 0; dly < 4; dly++) begin
            op(1, 1, 0, 20'hB0000, 0, "R3 acquire");
            idle_cyc(dly, "R12 gap");
            op(1, 0, 1, 20'hB0000, 32'h1, "R8 early release");
            op(1, 1, 0, 20'hB0000, 0, "R8 free after early release");
            op(1, 1, 0, 20'hB0000, 0, "R4 refused after reacquire");
            op(1, 0, 1, 20'hB0000, 32'h1, "R6 release");
        end

        // R7: write while free has no effect
        op(1, 0, 1, 20'hB0000, 32'h7, "R7 write while free");
        op(1, 0, 1, 20'hB0000, 32'h7, "R7 second write while free");
        op(1, 1, 0, 20'hB0000, 0, "R7 still free");
        op(1, 0, 1, 20'hB0000, 32'h1, "R6 release");

        // R9: read and write in one cycle
        op(1, 1, 1, 20'hB0000, 32'h1, "R9 collide while free");
        op(1, 1, 0, 20'hB0000, 0, "R9 free after collide");
        idle_cyc(3, "R12 gap");
        op(1, 1, 1, 20'hB0000, 32'h1, "R9 collide while held");
        op(1, 1, 0, 20'hB0000, 0, "R9 released by collide");
        op(1, 0, 1, 20'hB0000, 32'h1, "R6 release");

        // R2: byte offsets within the lock word
        for (int b = 1; b < 4; b++) begin
            op(1, 1, 0, 20'hB0000 + 20'(b), 0, "R2 lock byte alias acquire");
            op(1, 1, 0, 20'hB0000, 0, "R2 alias held");
            op(1, 0, 1, 20'hB0000 + 20'(b), 32'h1, "R2 lock byte alias release");
        end

        // R10: sweep the window while the lock is held
        op(1, 1, 0, 20'hB0000, 0, "R3 acquire");
        for (int o = 4; o < 32'h20000; o += 32'h3FC) begin
            op(1, 0, 1, 20'hB0000 + 20'(o), 32'hFFFF_FFFF, "R10 window write ignored");
            op(1, 1, 0, 20'hB0000 + 20'(o), 0, "R10 window read zero");
        end
        op(1, 0, 1, 20'hCFFFC, 32'h1, "R10 top word write ignored");
        op(1, 1, 0, 20'hCFFFF, 0, "R10 top byte read zero");
        op(1, 1, 0, 20'hB0000, 0, "R10 lock still held");

        // R11: outside the window and deselected
        op(1, 0, 1, 20'hAFFFF, 32'h1, "R11 below window write");
        op(1, 0, 1, 20'hD0000, 32'h1, "R11 above window write");
        op(1, 0, 1, 20'h00000, 32'h1, "R11 far write");
        op(0, 0, 1, 20'hB0000, 32'h1, "R11 deselected write");
        op(1, 1, 0, 20'hAFFFC, 0, "R11 below window read");
        op(1, 1, 0, 20'hB0000, 0, "R11 lock still held");
        op(1, 0, 1, 20'hB0000, 32'h1, "R6 release");
        op(0, 1, 0, 20'hB0000, 0, "R11 deselected read");
        op(1, 1, 0, 20'hD0000, 0, "R11 above window read");
        op(1, 1, 0, 20'hB0000, 0, "R11 still free after deselected read");
        op(1, 0, 1, 20'hB0000, 32'h1, "R6 release");

        // R3/R4: pseudo-random mix against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            logic [19:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[3:2])
                2'd0: a = 20'hB0000;
                2'd1: a = 20'hB0002;
                2'd2: a = 20'hB0000 + {4'h0, lfsr[15:4], 4'h4};
                default: a = 20'hD0000 + {8'h0, lfsr[15:4]};
            endcase
            op(lfsr[0] | lfsr[8], lfsr[1] | lfsr[9], lfsr[4] & lfsr[5] & lfsr[6], a,
               {lfsr, lfsr}, "R3 random mix");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule